// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block watches a pixel-clocked video byte stream that uses embedded timing references. It finds the start-of-active-video and end-of-active-video codes, decodes the status byte that follows each preamble, and keeps the current stream, field and vertical flags. Each data word that falls inside an active window leaves the block marked valid. Every output word also carries a stream tag and a blanking-region tag, and each decoded code raises a one-cycle strobe.

Three input modes exist. In the legacy 8-bit mode the T flag tells apart blanking data (T=0) and picture data (T=1), and the flags are taken only from end codes. In the two newer modes, one 8-bit and one 16-bit, T selects one of two interleaved streams and V marks the blanking region. In these modes the flags are taken from both start and end codes, and the low nibble of the status byte is passed out as four extension flags. These are non-interlaced, repeat, a reserved bit and an extension bit, in bits 3 down to 0. The streams can alternate line by line or field by field.

Top module: `vid_tref_decoder`

## Requirements
- R1: While `rst_n` is low every output is 0, and the block starts outside an active window.
- R2: A code is recognised when the luma lane carries 0xFF, 0x00, 0x00 in three consecutive cycles followed by a status byte. Status bit 7 is T, bit 6 is F, bit 5 is V and bit 4 is H. H=1 raises `eav_o` and H=0 raises `sav_o` for one cycle, in the cycle after the status byte was sampled.
- R3: A word sampled at clock edge k appears on `word_o` after edge k+3. `word_vld_o` is high only for words sampled after a start code's status byte and before the next end code's preamble. Preamble words, status bytes and blanking words are never valid.
- R4: In mode 0 (legacy), `vbi_o` is the inverse of the latched T and `stream_o` is 0. The flags change only at end codes, and start-code status bytes leave them untouched.
- R5: In modes 1 and 2, `stream_o` is the latched T and `vbi_o` is the latched V. Both are latched from start codes and from end codes.
- R6: In modes 1 and 2, `xflag_o` takes status bits 3..0 at every code. In mode 0 it is cleared to 0 at every code.
- R7: In mode 2 (or 3), `word_o` is {chroma, luma}. In modes 0 and 1 its upper byte is 0.
- R8: `field_o` holds the latched F, and follows the same update rule as the other flags in each mode.
- R9: The chroma lane never takes part in code detection. A preamble on the chroma lane alone raises no strobe.
- R10: When T alternates from line to line in modes 1 and 2, each line's words carry the T of that line's start code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 legacy 8-bit, 1 newer 8-bit, 2 or 3 newer 16-bit |
| luma_i | input | 8 | Luma lane; carries the codes |
| chroma_i | input | 8 | Chroma lane; used only in 16-bit mode |
| word_o | output | 16 | Delayed data word |
| word_vld_o | output | 1 | Word lies inside an active window |
| stream_o | output | 1 | Stream tag of the word |
| vbi_o | output | 1 | Blanking-region tag of the word |
| sav_o | output | 1 | Start code decoded |
| eav_o | output | 1 | End code decoded |
| field_o | output | 1 | Latched F flag |
| xflag_o | output | 4 | Latched extension flags |

## Verification
Data words come out three edges after they are sampled, so the last preamble byte can disqualify the words before it. The strobes, `field_o` and `xflag_o` change on the edge that samples the status byte. The tags on a word show the flags in force on the edge that outputs it. The bench keeps a queue model that is updated on each rising edge with these same latencies, and it compares every output at the following falling edge. Counters of valid words, per-stream words and strobes, read at idle points, check R3, R9 and R10 as totals.

// File: rtl/vid_tref_decoder.sv
`timescale 1ns/1ps
module vid_tref_decoder #(
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [LW-1:0]   luma_i,
  input  logic [LW-1:0]   chroma_i,
  output logic [2*LW-1:0] word_o,
  output logic            word_vld_o,
  output logic            stream_o,
  output logic            vbi_o,
  output logic            sav_o,
  output logic            eav_o,
  output logic            field_o,
  output logic [3:0]      xflag_o
);
  localparam int WW = 2 * LW;

  logic [LW-1:0] y1, y2, y3;
  logic [WW-1:0] w1, w2, w3;
  logic          v1, v2, v3;
  logic          act, t_q, v_q;

  wire level = (mode != 2'b00);
  wire wide  = mode[1];
  wire hit   = (y3 == {LW{1'b1}}) && (y2 == '0) && (y1 == '0);
  wire h_in  = luma_i[LW-4];
  wire [WW-1:0] w_in = wide ? {chroma_i, luma_i} : {{LW{1'b0}}, luma_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y1 <= '0; y2 <= '0; y3 <= '0;
      w1 <= '0; w2 <= '0; w3 <= '0;
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      act <= 1'b0; t_q <= 1'b0; v_q <= 1'b0;
      word_o <= '0; word_vld_o <= 1'b0;
      stream_o <= 1'b0; vbi_o <= 1'b0;
      sav_o <= 1'b0; eav_o <= 1'b0;
      field_o <= 1'b0; xflag_o <= '0;
    end else begin
      y1 <= luma_i; y2 <= y1; y3 <= y2;
      w1 <= w_in;   w2 <= w1; w3 <= w2;
      v1 <= act & ~hit;
      v2 <= v1 & ~hit;
      v3 <= v2 & ~hit;
      word_o     <= w3;
      word_vld_o <= v3 & ~hit;
      stream_o   <= level & t_q;
      vbi_o      <= level ? v_q : ~t_q;
      sav_o      <= hit & ~h_in;
      eav_o      <= hit & h_in;
      if (hit) begin
        act <= ~h_in;
        if (level || h_in) begin
          t_q     <= luma_i[LW-1];
          field_o <= luma_i[LW-2];
          v_q     <= luma_i[LW-3];
        end
        xflag_o <= level ? luma_i[LW-5 -: 4] : 4'h0;
      end
    end
  end

  AST_CODE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_o || eav_o) |=> (!sav_o && !eav_o)); // R2
  AST_CODE_NOT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_o || eav_o) |-> !word_vld_o); // R3
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    eav_o |=> !word_vld_o); // R3
  AST_LEGACY_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sav_o && $past(mode) == 2'b00) |-> $stable(field_o)); // R4
  AST_LEGACY_NO_XFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((sav_o || eav_o) && $past(mode) == 2'b00) |-> (xflag_o == 4'h0)); // R6
endmodule

// File: tb/tb_vid_tref_decoder.sv
`timescale 1ns/1ps
module tb_vid_tref_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] luma = 8'h00, chroma = 8'h00;
  logic [15:0] word_o;
  logic word_vld_o, stream_o, vbi_o, sav_o, eav_o, field_o;
  logic [3:0] xflag_o;

  always #2.5 clk = ~clk;

  vid_tref_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .luma_i(luma), .chroma_i(chroma),
    .word_o(word_o), .word_vld_o(word_vld_o), .stream_o(stream_o), .vbi_o(vbi_o),
    .sav_o(sav_o), .eav_o(eav_o), .field_o(field_o), .xflag_o(xflag_o)
  );

  int errors = 0, checks = 0;
  bit cmp_en = 0, done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [15:0] qw[$];
  bit qv[$];
  logic [7:0] hist[$];
  bit m_act, m_t, m_v, m_f, lvl, hit;
  logic [3:0] m_x;
  logic [15:0] e_word;
  bit e_vld, e_stream, e_vbi, e_sav, e_eav, e_field;
  logic [3:0] e_xf;

  always @(posedge clk) begin
    if (!rst_n) begin
      qw.delete(); qv.delete(); hist.delete();
      m_act = 0; m_t = 0; m_v = 0; m_f = 0; m_x = 0;
      e_word = 0; e_vld = 0; e_stream = 0; e_vbi = 0; e_sav = 0; e_eav = 0; e_field = 0; e_xf = 0;
    end else begin
      lvl = (mode != 2'b00);
      hit = (hist.size() == 3) && hist[0] == 8'hFF && hist[1] == 8'h00 && hist[2] == 8'h00;
      if (hit) foreach (qv[i]) qv[i] = 0;
      if (qw.size() == 3) begin
        e_word = qw.pop_front(); e_vld = qv.pop_front();
      end else begin
        e_word = 0; e_vld = 0;
      end
      e_stream = lvl & m_t;
      e_vbi = lvl ? m_v : !m_t;
      qw.push_back(mode[1] ? {chroma, luma} : {8'h00, luma});
      qv.push_back(hit ? 1'b0 : m_act);
      e_sav = hit & !luma[4];
      e_eav = hit & luma[4];
      if (hit) begin
        m_act = !luma[4];
        if (lvl || luma[4]) begin m_t = luma[7]; m_f = luma[6]; m_v = luma[5]; end
        m_x = lvl ? luma[3:0] : 4'h0;
      end
      e_field = m_f; e_xf = m_x;
      hist.push_back(luma);
      if (hist.size() > 3) void'(hist.pop_front());
    end
  end

  int n_vld = 0, n_s1 = 0, n_strobe = 0;
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R3 R7", "word", word_o, e_word);
      chk("R3", "valid", word_vld_o, e_vld);
      chk("R5 R10", "stream", stream_o, e_stream);
      chk("R4 R5", "vbi", vbi_o, e_vbi);
      chk("R2", "sav", sav_o, e_sav);
      chk("R2", "eav", eav_o, e_eav);
      chk("R6", "xflag", xflag_o, e_xf);
      chk("R8", "field", field_o, e_field);
      if (word_vld_o) n_vld++;
      if (word_vld_o && stream_o) n_s1++;
      if (sav_o || eav_o) n_strobe++;
    end
  end

  function automatic logic [7:0] st(bit t, bit f, bit v, bit h, logic [3:0] n);
    return {t, f, v, h, n};
  endfunction

  task automatic put(input logic [7:0] y, input logic [7:0] c);
    @(negedge clk);
    luma = y; chroma = c;
  endtask

  task automatic code(input logic [7:0] s);
    put(8'hFF, 8'h80); put(8'h00, 8'h80); put(8'h00, 8'h80); put(s, 8'h80);
  endtask

  task automatic line(input logic [7:0] e, input logic [7:0] s, input int nb, input int na);
    code(e);
    for (int k = 0; k < nb; k++) put(8'h10, 8'h80);
    code(s);
    for (int k = 0; k < na; k++) put(8'(16 + (k * 29) % 200), 8'(k * 71 + 3));
  endtask

  task automatic close_out(input logic [7:0] e);
    code(e);
    for (int k = 0; k < 6; k++) put(8'h10, 8'h80);
  endtask

  int b_vld, b_s1, b_str;

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk("R1", "word", word_o, 0); chk("R1", "valid", word_vld_o, 0);
    chk("R1", "strobes", {sav_o, eav_o}, 0); chk("R1", "tags", {stream_o, vbi_o, field_o}, 0);
    chk("R1", "xflag", xflag_o, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    for (int k = 0; k < 4; k++) put(8'h10, 8'h80);

    // legacy mode: R4 R6 R8, start-code flags ignored
    mode = 2'b00;
    b_vld = n_vld;
    line(st(1, 0, 0, 1, 4'h5), st(0, 1, 1, 0, 4'hA), 4, 6);
    line(st(0, 1, 1, 1, 4'h3), st(1, 0, 0, 0, 4'h3), 3, 5);
    close_out(st(1, 1, 0, 1, 4'hF));
    chk("R3", "legacy valid words", n_vld - b_vld, 11);

    // newer 8-bit mode, line-rate stream interleave: R5 R10
    mode = 2'b01;
    b_vld = n_vld; b_s1 = n_s1;
    line(st(0, 0, 1, 1, 4'h9), st(0, 0, 0, 0, 4'h9), 4, 5);
    line(st(1, 0, 1, 1, 4'h2), st(1, 0, 0, 0, 4'h6), 4, 7);
    line(st(0, 1, 0, 1, 4'h1), st(0, 1, 1, 0, 4'h8), 2, 5);
    line(st(1, 1, 1, 1, 4'hC), st(1, 1, 0, 0, 4'h4), 2, 7);
    close_out(st(0, 0, 1, 1, 4'h0));
    chk("R10", "stream-1 words", n_s1 - b_s1, 14);
    chk("R3", "level-I valid words", n_vld - b_vld, 24);

    // 16-bit mode: R7, and chroma-only preamble R9
    mode = 2'b10;
    line(st(1, 0, 1, 1, 4'h7), st(1, 0, 0, 0, 4'hB), 3, 8);
    close_out(st(0, 1, 1, 1, 4'h5));
    b_str = n_strobe;
    put(8'h10, 8'hFF); put(8'h10, 8'h00); put(8'h10, 8'h00); put(8'h10, 8'h9D);
    for (int k = 0; k < 5; k++) put(8'h10, 8'h80);
    chk("R9", "strobes from chroma", n_strobe - b_str, 0);
    mode = 2'b11;
    line(st(0, 0, 0, 1, 4'h3), st(0, 0, 0, 0, 4'hE), 2, 6);
    close_out(st(1, 0, 1, 1, 4'h1));

    // back to legacy after wide words: upper byte cleared
    mode = 2'b00;
    line(st(1, 0, 0, 1, 4'h0), st(1, 0, 0, 0, 4'h0), 2, 4);
    close_out(st(0, 0, 0, 1, 4'h0));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule